// File: doc/BRIEF.md
# Audio Channel and Format Adapter

This block sits between a multichannel sample stream coming from the audio side and a serial port on the client side. Each incoming sample is converted from the audio-side sample width to the client-side width. The channel layout of each frame is converted as well: a two-channel frame can be reduced to one channel, and a one-channel frame can be expanded to two. The converted samples are stored in a receive FIFO. A request output tells the consumer when more complete frames are stored than a programmable threshold allows.

Both sides use valid/ready handshakes and mark the last sample of each frame. Configuration inputs are expected to stay static while data is in flight. After any change to the configuration, a one-cycle synchronous flush brings the block back to a clean state.

Top module: `chan_fmt_adapter`

## Requirements
- R1: After reset, and in the cycle after a flush pulse, `out_valid` and `req` are low, the FIFO is empty and the next input sample is taken as channel 0. While `flush` is high, `in_ready` is low.
- R2: Width codes are 0 = 8 bits, 1 = 16 bits, and 2 or 3 = 32 bits. A sample occupies the low bits of its data word. Widening left-aligns the sample and fills the new low bits with zero. On `out_data`, the bits above the client width are zero.
- R3: Narrowing keeps the most significant client-width bits of the left-aligned sample.
- R4: Pass mode applies to every channel-count pair except those in R5 and R7. In pass mode, each input sample gives one output sample. `out_last` is set on the sample at channel position `cfg_in_ch` (channel count minus one) or on a sample that arrives with `in_last`.
- R5: Downmix mode applies when the audio side has 2 channels (`cfg_in_ch`=1) and the client side has 1 (`cfg_out_ch`=0). It emits one sample per frame, with `out_last` set. `cfg_s2m`=0 selects channel 0 and `cfg_s2m`=1 selects channel 1.
- R6: With `cfg_s2m` equal to 2 or 3, downmix outputs the floor of half the signed sum of the two left-aligned samples.
- R7: Upmix mode applies when the audio side has 1 channel and the client side has 2. Each input gives two outputs: first the sample, then either zero (`cfg_m2s`=0) or a copy (`cfg_m2s`=1). `out_last` is set only on the second output.
- R8: The effective threshold is the smaller of `cfg_thr` and (DEPTH / client frame channels) - 1. The client frame has 1 channel in downmix, 2 in upmix, and `cfg_in_ch`+1 in pass mode.
- R9: `req` is high while the number of complete frames held in the FIFO is greater than the effective threshold. A partial frame is not counted.
- R10: While `out_ready` is low, `out_valid`, `out_data` and `out_last` hold. When the FIFO holds DEPTH entries, `in_ready` is low and no sample is lost.
- R11: A sample accepted with `in_last` ends the frame early, and the next sample is channel 0.
- R12: A flush discards a channel-0 sample held for a downmix, so the next pair is converted on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Synchronous clear of FIFO and channel position |
| cfg_in_ch | input | CH_W | Audio-side channels minus one |
| cfg_out_ch | input | CH_W | Client-side channels minus one |
| cfg_in_w | input | 2 | Audio-side width code |
| cfg_out_w | input | 2 | Client-side width code |
| cfg_s2m | input | 2 | Downmix select: 0 ch0, 1 ch1, 2/3 average |
| cfg_m2s | input | 1 | Upmix select: 0 zero fill, 1 copy |
| cfg_thr | input | THR_W | Request threshold in frames |
| in_valid | input | 1 | Audio-side sample valid |
| in_ready | output | 1 | Audio-side sample accepted |
| in_data | input | 32 | Audio-side sample, low-aligned |
| in_last | input | 1 | Audio-side frame-last marker |
| out_valid | output | 1 | Client-side sample valid |
| out_ready | input | 1 | Client-side sample taken |
| out_data | output | 32 | Client-side sample, low-aligned |
| out_last | output | 1 | Client-side frame-last marker |
| req | output | 1 | More complete frames stored than threshold |

## Verification
`in_ready` is combinational from the current state and the FIFO fill level. A sample written at a clock edge appears on `out_valid`/`out_data` from that edge onward. `req` follows the stored frame count in the same cycle as the frame's last sample becomes visible. The effect of a flush shows one edge after the pulse. The bench drives inputs and samples outputs only at falling clock edges, and it checks `in_ready` just before the edge that would take a sample. Outputs are checked after buffering, by popping entries one at a time with `out_ready` pulsed for a single cycle, so every comparison is made against a settled registered value.

// File: rtl/chan_adapt_pkg.sv
// Package: shared types and sample conversion helpers for the channel and
// format adapter. Samples are handled internally left-aligned on 32 bits.
package chan_adapt_pkg;

    localparam int SAMPLE_W = 32;

    typedef enum logic [1:0] {
        CONV_PASS = 2'd0,
        CONV_DOWN = 2'd1,
        CONV_UP   = 2'd2
    } conv_mode_e;

    // Move a low-aligned sample of the coded width to the top of the word.
    function automatic logic [SAMPLE_W-1:0] left_align(input logic [SAMPLE_W-1:0] d,
                                                       input logic [1:0] wc);
        case (wc)
            2'd0:    return {d[7:0], 24'h0};
            2'd1:    return {d[15:0], 16'h0};
            default: return d;
        endcase
    endfunction

    // Keep the top bits of a left-aligned sample, returned low-aligned.
    function automatic logic [SAMPLE_W-1:0] narrow_low(input logic [SAMPLE_W-1:0] x,
                                                       input logic [1:0] wc);
        case (wc)
            2'd0:    return {24'h0, x[31:24]};
            2'd1:    return {16'h0, x[31:16]};
            default: return x;
        endcase
    endfunction

    // Signed average rounding toward negative infinity.
    function automatic logic [SAMPLE_W-1:0] avg_floor(input logic [SAMPLE_W-1:0] a,
                                                      input logic [SAMPLE_W-1:0] b);
        logic [SAMPLE_W:0] s;
        s = {a[SAMPLE_W-1], a} + {b[SAMPLE_W-1], b};
        return s[SAMPLE_W:1];
    endfunction

endpackage

// File: rtl/chan_conv.sv
// Channel and width converter. Takes audio-side samples and produces FIFO
// writes in client format. Assumes the FIFO write is only issued when
// wr_ready is high, and that configuration is static between flushes.
module chan_conv
    import chan_adapt_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  conv_mode_e          mode,
    input  logic [CH_W-1:0]     cfg_in_ch,
    input  logic [1:0]          cfg_in_w,
    input  logic [1:0]          cfg_out_w,
    input  logic [1:0]          cfg_s2m,
    input  logic                cfg_m2s,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic                in_last,
    output logic                in_ready,
    input  logic                wr_ready,
    output logic                wr_en,
    output logic [SAMPLE_W-1:0] wr_data,
    output logic                wr_last
);

    logic [CH_W-1:0]     ch_pos;
    logic                up_second;
    logic [SAMPLE_W-1:0] held;
    logic [SAMPLE_W-1:0] cur;
    logic [SAMPLE_W-1:0] res;
    logic                frame_end;
    logic                accept;

    // Decide readiness, write strobe and converted value for this cycle.
    always_comb begin
        cur       = left_align(in_data, cfg_in_w);
        frame_end = in_last || (ch_pos == cfg_in_ch);
        in_ready  = 1'b0;
        wr_en     = 1'b0;
        wr_last   = 1'b0;
        res       = cur;
        if (!flush) begin
            case (mode)
                CONV_DOWN: begin
                    if (ch_pos == '0 && !in_last) begin
                        in_ready = 1'b1;
                    end else begin
                        in_ready = wr_ready;
                        wr_en    = in_valid && wr_ready;
                        wr_last  = 1'b1;
                        if (ch_pos != '0) begin
                            case (cfg_s2m)
                                2'd0:    res = held;
                                2'd1:    res = cur;
                                default: res = avg_floor(held, cur);
                            endcase
                        end
                    end
                end
                CONV_UP: begin
                    wr_en = in_valid && wr_ready;
                    if (up_second) begin
                        in_ready = wr_ready;
                        wr_last  = 1'b1;
                        res      = cfg_m2s ? cur : '0;
                    end
                end
                default: begin
                    in_ready = wr_ready;
                    wr_en    = in_valid && wr_ready;
                    wr_last  = frame_end;
                end
            endcase
        end
        wr_data = narrow_low(res, cfg_out_w);
    end

    assign accept = in_valid && in_ready;

    // Track channel position, upmix phase and the held downmix sample.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ch_pos    <= '0;
            up_second <= 1'b0;
            held      <= '0;
        end else begin
            if (accept) begin
                ch_pos <= frame_end ? '0 : ch_pos + 1'b1;
                if (mode == CONV_DOWN && ch_pos == '0) begin
                    held <= cur;
                end
            end
            if (mode == CONV_UP && wr_en) begin
                up_second <= ~up_second;
            end
        end
    end

endmodule

// File: rtl/frame_fifo.sv
// Receive FIFO for converted samples with a frame-last flag per entry.
// Counts the complete frames stored. Assumes writes only when wr_ready.
module frame_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_last,
    output logic          wr_ready,
    input  logic          rd_ready,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          rd_last,
    output logic [CW-1:0] frames
);

    logic [DW:0]   mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          do_rd;

    assign wr_ready = (count != CW'(DEPTH));
    assign rd_valid = (count != '0) && !flush;
    assign {rd_last, rd_data} = mem[rd_ptr];
    assign do_rd    = rd_valid && rd_ready;

    // Store a written entry.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= {wr_last, wr_data};
        end
    end

    // Advance pointers and keep the entry and frame counts.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            frames <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_rd) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            count  <= count + CW'(wr_en) - CW'(do_rd);
            frames <= frames + CW'(wr_en && wr_last) - CW'(do_rd && rd_last);
        end
    end

endmodule

// File: rtl/frame_thresh.sv
// Threshold clamp and request. Assumes DEPTH is at least the largest
// channel count, so the quotient is never below one.
module frame_thresh #(
    parameter int DEPTH = 16,
    parameter int CH_W  = 4,
    parameter int THR_W = 5,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [CH_W:0]   frame_ch,
    input  logic [THR_W-1:0] cfg_thr,
    input  logic [CW-1:0]    frames,
    output logic             req
);

    logic [31:0] limit;
    logic [31:0] eff;

    // Clamp the programmed threshold and compare with stored frames.
    always_comb begin
        limit = 32'(DEPTH) / 32'(frame_ch) - 32'd1;
        eff   = (32'(cfg_thr) > limit) ? limit : 32'(cfg_thr);
        req   = 32'(frames) > eff;
    end

endmodule

// File: rtl/chan_fmt_adapter.sv
// Top of the audio channel and format adapter: decodes the conversion mode,
// then chains converter, receive FIFO and threshold logic.
module chan_fmt_adapter
    import chan_adapt_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CH_W  = 4,
    parameter int THR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [CH_W-1:0]  cfg_in_ch,
    input  logic [CH_W-1:0]  cfg_out_ch,
    input  logic [1:0]       cfg_in_w,
    input  logic [1:0]       cfg_out_w,
    input  logic [1:0]       cfg_s2m,
    input  logic             cfg_m2s,
    input  logic [THR_W-1:0] cfg_thr,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [31:0]      in_data,
    input  logic             in_last,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [31:0]      out_data,
    output logic             out_last,
    output logic             req
);

    localparam int CW = $clog2(DEPTH + 1);

    conv_mode_e    mode;
    logic [CH_W:0] frame_ch;
    logic          wr_en;
    logic          wr_ready;
    logic [31:0]   wr_data;
    logic          wr_last;
    logic [CW-1:0] frames;

    // Select the conversion mode and the client frame size.
    always_comb begin
        if (cfg_in_ch == CH_W'(1) && cfg_out_ch == '0) begin
            mode     = CONV_DOWN;
            frame_ch = (CH_W+1)'(1);
        end else if (cfg_in_ch == '0 && cfg_out_ch == CH_W'(1)) begin
            mode     = CONV_UP;
            frame_ch = (CH_W+1)'(2);
        end else begin
            mode     = CONV_PASS;
            frame_ch = {1'b0, cfg_in_ch} + 1'b1;
        end
    end

    chan_conv #(.CH_W(CH_W)) u_conv (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .mode     (mode),
        .cfg_in_ch(cfg_in_ch),
        .cfg_in_w (cfg_in_w),
        .cfg_out_w(cfg_out_w),
        .cfg_s2m  (cfg_s2m),
        .cfg_m2s  (cfg_m2s),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_last  (in_last),
        .in_ready (in_ready),
        .wr_ready (wr_ready),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_last  (wr_last)
    );

    frame_fifo #(.DEPTH(DEPTH), .DW(32)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_last (wr_last),
        .wr_ready(wr_ready),
        .rd_ready(out_ready),
        .rd_valid(out_valid),
        .rd_data (out_data),
        .rd_last (out_last),
        .frames  (frames)
    );

    frame_thresh #(.DEPTH(DEPTH), .CH_W(CH_W), .THR_W(THR_W)) u_thr (
        .frame_ch(frame_ch),
        .cfg_thr (cfg_thr),
        .frames  (frames),
        .req     (req)
    );

endmodule

// File: rtl/chan_fmt_adapter_chk.sv
// Checker for the adapter's port-level protocol, bound to every instance.
module chan_fmt_adapter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        flush,
    input logic        in_valid,
    input logic        in_ready,
    input logic        in_last,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic        out_last,
    input logic        req
);

    // R1: a flush leaves the output empty and the request low.
    a_r1_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!out_valid && !req));

    // R9: a request implies stored data.
    a_r9_req_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !flush) |-> out_valid);

    // R10: a stalled output holds its value.
    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=>
            (flush || (out_valid && $stable(out_data) && $stable(out_last))));

    // R4: a frame-ending input always lands in the FIFO.
    a_r4_last_written: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last && !flush) |=> (out_valid || flush));

endmodule

bind chan_fmt_adapter chan_fmt_adapter_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_last  (in_last),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_last (out_last),
    .req      (req)
);

// File: tb/chan_fmt_adapter_tb_top.sv
// Self-checking bench for the channel and format adapter.
module chan_fmt_adapter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [3:0]  cfg_in_ch = 4'd1;
    logic [3:0]  cfg_out_ch = 4'd1;
    logic [1:0]  cfg_in_w = 2'd2;
    logic [1:0]  cfg_out_w = 2'd2;
    logic [1:0]  cfg_s2m = 2'd0;
    logic        cfg_m2s = 1'b0;
    logic [4:0]  cfg_thr = 5'd0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        out_last;
    logic        req;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    chan_fmt_adapter dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .cfg_in_ch(cfg_in_ch), .cfg_out_ch(cfg_out_ch),
        .cfg_in_w(cfg_in_w), .cfg_out_w(cfg_out_w),
        .cfg_s2m(cfg_s2m), .cfg_m2s(cfg_m2s), .cfg_thr(cfg_thr),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last), .req(req)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int wbits(input int code);
        return (code == 0) ? 8 : (code == 1) ? 16 : 32;
    endfunction

    function automatic logic [31:0] align_exp(input logic [31:0] d, input int wi);
        longint unsigned v;
        int b = wbits(wi);
        v = (longint'(d) & ((64'd1 << b) - 64'd1)) << (32 - b);
        return v[31:0];
    endfunction

    function automatic logic [31:0] fmt_exp(input logic [31:0] d, input int wi, input int wo);
        return align_exp(d, wi) >> (32 - wbits(wo));
    endfunction

    function automatic logic [31:0] avg_exp(input logic [31:0] a, input logic [31:0] b,
                                            input int wi, input int wo);
        longint sa = longint'(signed'(align_exp(a, wi)));
        longint sb = longint'(signed'(align_exp(b, wi)));
        longint s = (sa + sb) >>> 1;
        logic [31:0] r = s[31:0];
        return r >> (32 - wbits(wo));
    endfunction

    // Called at a falling edge; returns at the falling edge after acceptance.
    task automatic push(input logic [31:0] d, input logic l);
        in_valid = 1'b1;
        in_data  = d;
        in_last  = l;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic pop(input string tag, input logic [31:0] d, input logic l);
        check({tag, " valid"}, 64'(out_valid), 64'd1);
        check(tag, {31'd0, out_last, out_data}, {31'd0, l, d});
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        logic [31:0] b;
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", 64'(out_valid), 64'd0);
        check("R1 reset req", 64'(req), 64'd0);
        check("R1 reset in_ready", 64'(in_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3 width sweep in mono pass mode
        cfg_in_ch = 4'd0; cfg_out_ch = 4'd0;
        for (int wi = 0; wi < 4; wi++) begin
            for (int wo = 0; wo < 4; wo++) begin
                cfg_in_w = 2'(wi); cfg_out_w = 2'(wo);
                do_flush();
                push(32'hA5C3_96F1, 1'b0);
                push(32'h0000_8001, 1'b0);
                pop((wbits(wo) >= wbits(wi)) ? "R2 widen" : "R3 narrow",
                    fmt_exp(32'hA5C3_96F1, wi, wo), 1'b1);
                pop((wbits(wo) >= wbits(wi)) ? "R2 widen" : "R3 narrow",
                    fmt_exp(32'h0000_8001, wi, wo), 1'b1);
            end
        end

        // R4 pass mode, 3 audio channels with unrelated client count
        cfg_in_w = 2'd1; cfg_out_w = 2'd2;
        cfg_in_ch = 4'd2; cfg_out_ch = 4'd4;
        do_flush();
        for (int k = 0; k < 6; k++) push(32'(16'h1000 + k), 1'b0);
        for (int k = 0; k < 6; k++)
            pop("R4 pass frame", fmt_exp(32'(16'h1000 + k), 1, 2), (k % 3) == 2);

        // R11 early in_last restarts the channel position
        cfg_in_ch = 4'd3; cfg_out_ch = 4'd3; cfg_in_w = 2'd2;
        do_flush();
        push(32'h11, 1'b0); push(32'h22, 1'b1);
        for (int k = 0; k < 4; k++) push(32'(8'h30 + k), 1'b0);
        pop("R11 early last", 32'h11, 1'b0);
        pop("R11 early last", 32'h22, 1'b1);
        for (int k = 0; k < 4; k++) pop("R11 restart", 32'(8'h30 + k), k == 3);

        // R5/R6 downmix modes over several pairs and widths
        cfg_in_ch = 4'd1; cfg_out_ch = 4'd0;
        for (int m = 0; m < 4; m++) begin
            for (int wsel = 1; wsel < 3; wsel++) begin
                cfg_s2m = 2'(m); cfg_in_w = 2'(wsel); cfg_out_w = 2'(wsel);
                do_flush();
                for (int p = 0; p < 4; p++) begin
                    a = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h3 :
                        (p == 2) ? 32'h8000_8000 : 32'h7FFF_7FFF;
                    b = (p == 0) ? 32'h0 : (p == 1) ? 32'h4 :
                        (p == 2) ? 32'h8000_0001 : 32'h0001_0001;
                    push(a, 1'b0); push(b, 1'b0);
                    if (m == 0) pop("R5 left", fmt_exp(a, wsel, wsel), 1'b1);
                    else if (m == 1) pop("R5 right", fmt_exp(b, wsel, wsel), 1'b1);
                    else pop("R6 average", avg_exp(a, b, wsel, wsel), 1'b1);
                end
            end
        end

        // R7 upmix zero and copy
        cfg_in_ch = 4'd0; cfg_out_ch = 4'd1; cfg_in_w = 2'd0; cfg_out_w = 2'd1;
        for (int c = 0; c < 2; c++) begin
            cfg_m2s = c[0];
            do_flush();
            push(32'hC7, 1'b0); push(32'h5A, 1'b0);
            pop("R7 upmix first", fmt_exp(32'hC7, 0, 1), 1'b0);
            pop("R7 upmix second", c ? fmt_exp(32'hC7, 0, 1) : 32'h0, 1'b1);
            pop("R7 upmix first", fmt_exp(32'h5A, 0, 1), 1'b0);
            pop("R7 upmix second", c ? fmt_exp(32'h5A, 0, 1) : 32'h0, 1'b1);
        end

        // R9 request counts complete frames against an unclamped threshold
        cfg_in_ch = 4'd1; cfg_out_ch = 4'd1; cfg_in_w = 2'd2; cfg_out_w = 2'd2;
        cfg_thr = 5'd3;
        do_flush();
        for (int f = 0; f < 3; f++) begin push(32'(f), 1'b0); push(32'(f), 1'b0); end
        check("R9 req at threshold", 64'(req), 64'd0);
        push(32'h9, 1'b0);
        check("R9 partial frame not counted", 64'(req), 64'd0);
        push(32'h9, 1'b0);
        check("R9 req above threshold", 64'(req), 64'd1);
        pop("R9 drain", 32'h0, 1'b0);
        pop("R9 drain", 32'h0, 1'b1);
        check("R9 req drops", 64'(req), 64'd0);

        // R8 clamp for 4 and 8 channels
        cfg_in_ch = 4'd3; cfg_out_ch = 4'd3; cfg_thr = 5'd10;
        do_flush();
        for (int k = 0; k < 12; k++) push(32'(k), 1'b0);
        check("R8 clamp 4ch below", 64'(req), 64'd0);
        for (int k = 0; k < 4; k++) push(32'(k), 1'b0);
        check("R8 clamp 4ch reached", 64'(req), 64'd1);
        cfg_in_ch = 4'd7; cfg_out_ch = 4'd7; cfg_thr = 5'd31;
        do_flush();
        for (int k = 0; k < 8; k++) push(32'(k), 1'b0);
        check("R8 clamp 8ch below", 64'(req), 64'd0);
        for (int k = 0; k < 8; k++) push(32'(k), 1'b0);
        check("R8 clamp 8ch reached", 64'(req), 64'd1);

        // R10 full FIFO stalls input, order kept
        cfg_in_ch = 4'd0; cfg_out_ch = 4'd0; cfg_thr = 5'd0;
        do_flush();
        for (int k = 0; k < 16; k++) push(32'(32'hF00 + k), 1'b0);
        in_valid = 1'b1; in_data = 32'hDEAD;
        #1;
        check("R10 full stalls input", 64'(in_ready), 64'd0);
        in_valid = 1'b0;
        @(negedge clk);
        check("R10 stalled output held", 64'(out_data), 64'(32'hF00));
        for (int k = 0; k < 16; k++) pop("R10 order", 32'(32'hF00 + k), 1'b1);
        check("R10 nothing extra", 64'(out_valid), 64'd0);

        // R12 flush discards a held downmix sample; R1 flush empties FIFO
        cfg_in_ch = 4'd1; cfg_out_ch = 4'd0; cfg_s2m = 2'd2;
        do_flush();
        push(32'h4000_0000, 1'b0);
        flush = 1'b1;
        #1;
        check("R1 in_ready low in flush", 64'(in_ready), 64'd0);
        @(negedge clk);
        flush = 1'b0;
        push(32'h0000_0010, 1'b0); push(32'h0000_0020, 1'b0);
        pop("R12 fresh pair", avg_exp(32'h10, 32'h20, 2, 2), 1'b1);
        push(32'h1, 1'b0); push(32'h2, 1'b0); push(32'h3, 1'b0); push(32'h4, 1'b0);
        cfg_thr = 5'd0;
        check("R1 pre-flush req", 64'(req), 64'd1);
        do_flush();
        check("R1 flush out_valid", 64'(out_valid), 64'd0);
        check("R1 flush req", 64'(req), 64'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule